// File: doc/BRIEF.md
# Two-Output Priority Interrupt Sorter

This block takes a vector of already-masked pending interrupt lines and chooses, for each of two processor inputs, the single most urgent request. The two inputs are a normal interrupt (IRQ) and a fast interrupt (FIQ). Every line owns a small level register. That register holds a 6-bit urgency number and a bit that routes the line to one of the two outputs. Two independent arbiters each pick their best candidate. An arbiter then captures the winner's line number and urgency and raises its output.

A captured winner is held, whatever happens on the pending lines, until software writes the matching agreement bit. That write drops the output and re-arms the arbiter for a fresh decision. A global threshold register can block requests whose urgency number is too large. If the captured line is no longer pending, a spurious flag next to the captured number tells software so.

Top module: `prio_irq_sorter`

## Requirements
- R1: After reset both outputs are low, both captured numbers and urgencies read 0, the threshold is 0xFF (filter off), and every level register is 0, so every line goes to IRQ at urgency 0.
- R2: A level write (`lvl_we`, line `lvl_sel`) stores the routing bit from data bit 0, where 0 means IRQ and 1 means FIQ, and the urgency from data bits 7:2. Data bit 1 is ignored.
- R3: Among eligible pending lines, the smallest urgency number wins. If urgency numbers are equal, the lowest line number wins.
- R4: IRQ-routed lines compete only for the IRQ output and FIQ-routed lines only for the FIQ output. The two arbiters capture and release independently.
- R5: While an output is high, its captured number and urgency stay constant regardless of pending-line changes, until its agreement bit is written.
- R6: A control write with data bit 0 set drops the IRQ output at the next clock edge. Data bit 1 does the same for FIQ.
- R7: After a release, the arbiter captures again one clock later if any eligible line is pending. The output is therefore low for exactly one cycle when requests remain.
- R8: With threshold T not equal to 0xFF, only lines whose urgency number is strictly less than T are eligible. T = 0 blocks all lines.
- R9: `irq_spur` / `fiq_spur` is 1 while the output is high and the captured line is no longer pending.
- R10: An agreement write while no winner is held only re-arms that arbiter. The output stays low in the cycle after the write, even if a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend | input | 128 | Masked pending lines, bit n = line n |
| lvl_we | input | 1 | Level register write strobe |
| lvl_sel | input | 7 | Line whose level register is written |
| lvl_wdata | input | 8 | Level data: bit 0 route, bits 7:2 urgency |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | New threshold value |
| ctl_we | input | 1 | Agreement control write strobe |
| ctl_wdata | input | 2 | Bit 0 releases IRQ, bit 1 releases FIQ |
| irq_o | output | 1 | IRQ request to the processor |
| irq_num | output | 7 | Captured IRQ line number |
| irq_prio | output | 6 | Captured IRQ urgency |
| irq_spur | output | 1 | Captured IRQ line no longer pending |
| fiq_o | output | 1 | FIQ request to the processor |
| fiq_num | output | 7 | Captured FIQ line number |
| fiq_prio | output | 6 | Captured FIQ urgency |
| fiq_spur | output | 1 | Captured FIQ line no longer pending |

## Verification
Several properties are checked on every cycle:
- a held winner keeps its number and urgency until it is released;
- an agreement bit always drops its output on the next edge;
- a new capture never happens in the same cycle as a release;
- every new capture names a line that was pending and that passed the threshold.

Some behaviour only the bench scenarios can show:
- the choice of the right winner among competitors, including ties;
- the routing of lines by their level registers;
- the one-cycle gap before a re-capture;
- the spurious flag;
- the blocking effect of particular threshold values.

// File: rtl/irqs_pkg.sv
// Package: default sizes and shared constants of the priority interrupt sorter.
// Assumes the line count is a power of two (the sorting tree relies on it).
package irqs_pkg;
    localparam int LINES   = 128;
    localparam int PRIO_W  = 6;
    localparam int THR_W   = 8;
    localparam int NOUT    = 2;

    // Routing values held in level bit 0.
    typedef enum logic {
        ROUTE_IRQ = 1'b0,
        ROUTE_FIQ = 1'b1
    } route_e;
endpackage

// File: rtl/lvl_bank.sv
// Module: per-line level storage. Each line keeps a routing bit and an
// urgency number; both reset to 0. Assumes sel is below N when we is high.
module lvl_bank #(
    parameter int N  = 128,
    parameter int PW = 6,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   sel,
    input  logic [PW+1:0]   wdata,
    output logic [N-1:0]    route,
    output logic [PW-1:0]   prio [N]
);
    logic unused_rsvd_bit;
    assign unused_rsvd_bit = wdata[1];

    for (genvar i = 0; i < N; i++) begin : g_line
        // Purpose: hold one line's routing bit and urgency.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route[i] <= 1'b0;
                prio[i]  <= '0;
            end else if (we && sel == IW'(i)) begin
                route[i] <= wdata[0];
                prio[i]  <= wdata[PW+1:2];
            end
        end
    end
endmodule

// File: rtl/sort_tree.sv
// Module: combinational comparison tree. Finds the valid candidate with the
// smallest urgency; ties go to the lower index. Assumes N is a power of two,
// so every left subtree holds only lower indices than its right sibling.
module sort_tree #(
    parameter int N  = 128,
    parameter int PW = 6,
    localparam int IW = $clog2(N),
    localparam int NODES = 2 * N - 1
) (
    input  logic [N-1:0]  vld,
    input  logic [PW-1:0] prio [N],
    output logic          win_vld,
    output logic [PW-1:0] win_prio,
    output logic [IW-1:0] win_idx
);
    logic          nv [NODES];
    logic [PW-1:0] np [NODES];
    logic [IW-1:0] ni [NODES];

    for (genvar j = 0; j < N; j++) begin : g_leaf
        assign nv[N-1+j] = vld[j];
        assign np[N-1+j] = prio[j];
        assign ni[N-1+j] = IW'(j);
    end

    for (genvar k = 0; k < N - 1; k++) begin : g_node
        logic take_r;
        // Purpose: right child wins only with a strictly smaller urgency.
        assign take_r = nv[2*k+2] && (!nv[2*k+1] || np[2*k+2] < np[2*k+1]);
        assign nv[k]  = nv[2*k+1] | nv[2*k+2];
        assign np[k]  = take_r ? np[2*k+2] : np[2*k+1];
        assign ni[k]  = take_r ? ni[2*k+2] : ni[2*k+1];
    end

    assign win_vld  = nv[0];
    assign win_prio = np[0];
    assign win_idx  = ni[0];
endmodule

// File: rtl/grant_hold.sv
// Module: capture-and-hold stage for one output. Captures the tree winner
// while idle, holds it until release; a release takes precedence over a
// capture in the same cycle.
module grant_hold #(
    parameter int PW = 6,
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          release_i,
    input  logic          win_vld,
    input  logic [PW-1:0] win_prio,
    input  logic [IW-1:0] win_idx,
    output logic          active,
    output logic [IW-1:0] num,
    output logic [PW-1:0] prio
);
    // Purpose: idle/held state machine with captured winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            num    <= '0;
            prio   <= '0;
        end else if (release_i) begin
            active <= 1'b0;
        end else if (!active && win_vld) begin
            active <= 1'b1;
            num    <= win_idx;
            prio   <= win_prio;
        end
    end
endmodule

// File: rtl/prio_irq_sorter.sv
// Module: top of the priority interrupt sorter. Filters pending lines by
// routing and threshold, sorts each group, and holds one winner per output
// until software writes the agreement bit. Assumes pend is already masked
// and synchronous to clk.
module prio_irq_sorter #(
    parameter int LINES  = irqs_pkg::LINES,
    parameter int PRIO_W = irqs_pkg::PRIO_W,
    parameter int THR_W  = irqs_pkg::THR_W,
    localparam int IDX_W = $clog2(LINES),
    localparam int LVL_W = PRIO_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   pend,
    input  logic               lvl_we,
    input  logic [IDX_W-1:0]   lvl_sel,
    input  logic [LVL_W-1:0]   lvl_wdata,
    input  logic               thr_we,
    input  logic [THR_W-1:0]   thr_wdata,
    input  logic               ctl_we,
    input  logic [1:0]         ctl_wdata,
    output logic               irq_o,
    output logic [IDX_W-1:0]   irq_num,
    output logic [PRIO_W-1:0]  irq_prio,
    output logic               irq_spur,
    output logic               fiq_o,
    output logic [IDX_W-1:0]   fiq_num,
    output logic [PRIO_W-1:0]  fiq_prio,
    output logic               fiq_spur
);
    import irqs_pkg::*;

    logic [LINES-1:0]  route;
    logic [PRIO_W-1:0] lprio [LINES];
    logic [THR_W-1:0]  thr_q;
    logic              thr_off;
    logic [LINES-1:0]  admit;
    logic [LINES-1:0]  cand [NOUT];
    logic              w_vld  [NOUT];
    logic [PRIO_W-1:0] w_prio [NOUT];
    logic [IDX_W-1:0]  w_idx  [NOUT];
    logic              act    [NOUT];
    logic [IDX_W-1:0]  cap_num  [NOUT];
    logic [PRIO_W-1:0] cap_prio [NOUT];

    lvl_bank #(.N(LINES), .PW(PRIO_W)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lvl_we),
        .sel   (lvl_sel),
        .wdata (lvl_wdata),
        .route (route),
        .prio  (lprio)
    );

    // Purpose: threshold register, all ones (filter off) after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_q <= '1;
        else if (thr_we) thr_q <= thr_wdata;
    end

    assign thr_off = &thr_q;

    for (genvar i = 0; i < LINES; i++) begin : g_filt
        assign admit[i]   = thr_off || (THR_W'(lprio[i]) < thr_q);
        assign cand[0][i] = pend[i] && admit[i] && (route[i] == ROUTE_IRQ);
        assign cand[1][i] = pend[i] && admit[i] && (route[i] == ROUTE_FIQ);
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        sort_tree #(.N(LINES), .PW(PRIO_W)) u_tree (
            .vld      (cand[o]),
            .prio     (lprio),
            .win_vld  (w_vld[o]),
            .win_prio (w_prio[o]),
            .win_idx  (w_idx[o])
        );

        grant_hold #(.PW(PRIO_W), .IW(IDX_W)) u_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .release_i (ctl_we && ctl_wdata[o]),
            .win_vld   (w_vld[o]),
            .win_prio  (w_prio[o]),
            .win_idx   (w_idx[o]),
            .active    (act[o]),
            .num       (cap_num[o]),
            .prio      (cap_prio[o])
        );
    end

    assign irq_o    = act[0];
    assign irq_num  = cap_num[0];
    assign irq_prio = cap_prio[0];
    assign irq_spur = act[0] && !pend[cap_num[0]];
    assign fiq_o    = act[1];
    assign fiq_num  = cap_num[1];
    assign fiq_prio = cap_prio[1];
    assign fiq_spur = act[1] && !pend[cap_num[1]];
endmodule

// File: rtl/prio_irq_sorter_chk.sv
// Module: property checker bound to the sorter top. Watches the outputs,
// the control strobe and the threshold register over time.
module prio_irq_sorter_chk #(
    parameter int LINES  = 128,
    parameter int PRIO_W = 6,
    parameter int THR_W  = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LINES-1:0]  pend,
    input logic              ctl_we,
    input logic [1:0]        ctl_wdata,
    input logic [THR_W-1:0]  thr_q,
    input logic              irq_o,
    input logic [IDX_W-1:0]  irq_num,
    input logic [PRIO_W-1:0] irq_prio,
    input logic              fiq_o,
    input logic [IDX_W-1:0]  fiq_num,
    input logic [PRIO_W-1:0] fiq_prio
);
    logic [LINES-1:0] pend_d;

    // Purpose: one-cycle copy of the pending lines for capture checks.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_d <= '0;
        else        pend_d <= pend;
    end

    p_hold_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !(ctl_we && ctl_wdata[0]) |=> irq_o && $stable(irq_num) && $stable(irq_prio));
    p_hold_fiq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o && !(ctl_we && ctl_wdata[1]) |=> fiq_o && $stable(fiq_num) && $stable(fiq_prio));
    p_drop_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && ctl_wdata[0] |=> !irq_o);
    p_drop_fiq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && ctl_wdata[1] |=> !fiq_o);
    p_thr_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (&$past(thr_q)) || (THR_W'(irq_prio) < $past(thr_q)));
    p_thr_fiq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_o) |-> (&$past(thr_q)) || (THR_W'(fiq_prio) < $past(thr_q)));
    p_src_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> pend_d[irq_num]);
    p_src_fiq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_o) |-> pend_d[fiq_num]);
    p_no_cap_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !$past(ctl_we && ctl_wdata[0]));
endmodule

bind prio_irq_sorter prio_irq_sorter_chk #(
    .LINES(LINES), .PRIO_W(PRIO_W), .THR_W(THR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .thr_q     (thr_q),
    .irq_o     (irq_o),
    .irq_num   (irq_num),
    .irq_prio  (irq_prio),
    .fiq_o     (fiq_o),
    .fiq_num   (fiq_num),
    .fiq_prio  (fiq_prio)
);

// File: tb/sim_prio_irq_sorter.sv
module sim_prio_irq_sorter;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] pend = '0;
    logic         lvl_we = 1'b0;
    logic [6:0]   lvl_sel = '0;
    logic [7:0]   lvl_wdata = '0;
    logic         thr_we = 1'b0;
    logic [7:0]   thr_wdata = '0;
    logic         ctl_we = 1'b0;
    logic [1:0]   ctl_wdata = '0;
    logic         irq_o, irq_spur, fiq_o, fiq_spur;
    logic [6:0]   irq_num, fiq_num;
    logic [5:0]   irq_prio, fiq_prio;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [12:0] q_irq [$];
    logic [12:0] q_fiq [$];
    logic irq_prev = 1'b0;
    logic fiq_prev = 1'b0;

    prio_irq_sorter u0 (.*);

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_irq(input int n, input int p);
        q_irq.push_back({7'(n), 6'(p)});
    endtask

    task automatic push_fiq(input int n, input int p);
        q_fiq.push_back({7'(n), 6'(p)});
    endtask

    task automatic wr_lvl(input int idx, input logic [7:0] d);
        lvl_we = 1'b1; lvl_sel = 7'(idx); lvl_wdata = d;
        @(negedge clk);
        lvl_we = 1'b0;
    endtask

    task automatic wr_thr(input logic [7:0] d);
        thr_we = 1'b1; thr_wdata = d;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic ack(input logic [1:0] b);
        ctl_we = 1'b1; ctl_wdata = b;
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: on each new capture, pop the expected winner and compare (R3, R4).
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_o && !irq_prev) begin
                if (q_irq.size() == 0) chk(1'b0, "R3 irq unexpected", int'(irq_num), -1);
                else begin
                    logic [12:0] e;
                    e = q_irq.pop_front();
                    chk({irq_num, irq_prio} == e, "R3 irq winner",
                        int'({irq_num, irq_prio}), int'(e));
                end
            end
            if (fiq_o && !fiq_prev) begin
                if (q_fiq.size() == 0) chk(1'b0, "R4 fiq unexpected", int'(fiq_num), -1);
                else begin
                    logic [12:0] e;
                    e = q_fiq.pop_front();
                    chk({fiq_num, fiq_prio} == e, "R4 fiq winner",
                        int'({fiq_num, fiq_prio}), int'(e));
                end
            end
        end
        irq_prev <= irq_o;
        fiq_prev <= fiq_o;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        chk(irq_o == 1'b0, "R1 irq_o", irq_o, 0);
        chk(fiq_o == 1'b0, "R1 fiq_o", fiq_o, 0);
        chk(irq_num == 7'd0, "R1 irq_num", irq_num, 0);
        chk(fiq_prio == 6'd0, "R1 fiq_prio", fiq_prio, 0);

        // R1/R3: default levels, tie at urgency 0 -> lower line 5
        push_irq(5, 0);
        pend = '0; pend[5] = 1'b1; pend[9] = 1'b1;
        idle(2);
        pend = '0; pend[9] = 1'b1;
        idle(2);
        chk(irq_o && irq_num == 7'd5, "R5 hold", irq_num, 5);
        chk(irq_spur == 1'b1, "R9 spurious", irq_spur, 1);
        chk(fiq_o == 1'b0, "R4 fiq idle", fiq_o, 0);
        push_irq(9, 0);
        ack(2'b01);
        chk(irq_o == 1'b0, "R6 drop", irq_o, 0);
        idle(1);
        chk(irq_o == 1'b1, "R7 recapture", irq_o, 1);
        chk(irq_spur == 1'b0, "R9 not spurious", irq_spur, 0);
        pend = '0;
        ack(2'b01);
        idle(2);
        chk(irq_o == 1'b0, "R10 idle ack", irq_o, 0);

        // R10: release while idle with a pending line
        push_irq(3, 0);
        pend[3] = 1'b1;
        ack(2'b01);
        chk(irq_o == 1'b0, "R10 no capture on ack", irq_o, 0);
        idle(2);
        pend = '0;
        ack(2'b01);

        // R2/R4: program levels (bit 1 set on line 40 must be ignored)
        wr_lvl(20, 8'h0C);
        wr_lvl(40, 8'h06);
        wr_lvl(60, 8'h09);
        wr_lvl(61, 8'h09);
        wr_lvl(127, 8'h05);
        push_irq(40, 1);
        push_fiq(60, 2);
        pend[20] = 1'b1; pend[40] = 1'b1; pend[60] = 1'b1; pend[61] = 1'b1;
        idle(3);
        push_irq(20, 3);
        push_fiq(127, 1);
        pend = '0; pend[20] = 1'b1; pend[61] = 1'b1; pend[127] = 1'b1;
        ack(2'b11);
        idle(3);
        pend = '0;
        ack(2'b11);
        idle(1);

        // R8: threshold filtering
        wr_thr(8'd3);
        pend[20] = 1'b1;
        idle(3);
        chk(irq_o == 1'b0, "R8 blocked at equal", irq_o, 0);
        push_irq(40, 1);
        pend[40] = 1'b1;
        idle(3);
        pend = '0; pend[20] = 1'b1;
        ack(2'b01);
        idle(3);
        chk(irq_o == 1'b0, "R8 still blocked", irq_o, 0);
        push_irq(20, 3);
        wr_thr(8'hFF);
        idle(3);
        pend = '0;
        ack(2'b11);
        wr_thr(8'd0);
        pend[40] = 1'b1;
        idle(3);
        chk(irq_o == 1'b0, "R8 zero blocks all", irq_o, 0);
        push_irq(40, 1);
        wr_thr(8'hFF);
        idle(3);
        chk(irq_o == 1'b1 && irq_num == 7'd40, "R8 filter off", irq_num, 40);

        chk(q_irq.size() == 0, "R3 irq queue drained", q_irq.size(), 0);
        chk(q_fiq.size() == 0, "R4 fiq queue drained", q_fiq.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule